// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host read and write a 2048 x 8 asynchronous static RAM whose data pins are shared between reads and writes. The host raises a request with a direction flag, an address and (for writes) a data byte; the controller then sequences the memory's active-low chip select, output enable and write strobe. It counts every interval in system clocks, so the memory's minimum access, pulse and setup times are met at a 100 MHz clock. A single-cycle ready pulse marks completion. Read results are held in an output register.

A read keeps chip select and output enable low for two clocks and captures the bus on the second rising edge. A write first spends one clock selected with output enable high and the bus released, so the memory has stopped driving. It then drives the data with the write strobe low for two clocks. On one edge it raises the strobe, releases the bus driver and deselects the chip, so the memory never drives back into a write. Requests seen while a transfer runs are dropped.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and right after it, chip select, output enable and write strobe are high, the data driver enable is low and ready is low.
- R2: A read keeps chip select and output enable low and the write strobe high for exactly 2 clocks. Ready is high in the third cycle after the cycle in which the request was sampled.
- R3: The byte captured by a read equals the last byte written to that address. The rdata output keeps that value until the next read completes, even across writes.
- R4: The first clock of a write has chip select low, output enable high, write strobe high and the data driver disabled.
- R5: In the next 2 clocks of a write, the write strobe is low and the data driver is enabled with the requested byte held steady. Whenever the write strobe is low, output enable stays high and chip select stays low.
- R6: The write strobe rises on the same clock edge that disables the data driver and raises chip select. Ready follows one write request after 4 cycles.
- R7: Ready is high for exactly one cycle per completed transfer.
- R8: A request asserted while a transfer is in progress has no effect: no memory location changes and the running transfer continues unaltered.
- R9: The controller never enables its data driver while output enable is low or the write strobe is high.
- R10: The memory address does not change while chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req | input | 1 | Transfer request, sampled while the controller is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Single-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_addr | output | 11 | Memory address |
| sram_dq_o | output | 8 | Data driven toward the shared bus |
| sram_dq_oe | output | 1 | Tri-state enable for sram_dq_o |
| sram_dq_i | input | 8 | Data sampled from the shared bus |

## Verification
The assertions take for granted that the host holds the request for a single cycle while the controller is idle, and that any request arriving mid-transfer is meant to be dropped. They also assume rdata comes only from the resolved bus. The stimulus drives all host inputs half a cycle away from the active edge. It raises requests only when the previous ready has been seen, except for deliberate mid-transfer requests. A behavioural memory with a 15 ns access delay resolves the shared bus, checks write pulse width, data setup and bus contention, and is swept over every address.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WSET  = 2'd2,
    ST_WPULS = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_CLKS   = 2,
  parameter int WSET_CLKS = 1,
  parameter int WPUL_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_write,
  output ctl_state_t st_next,
  output logic       accept,
  output logic       capture,
  output logic       done
);
  localparam int MAXC  = (RD_CLKS > WPUL_CLKS) ? ((RD_CLKS > WSET_CLKS) ? RD_CLKS : WSET_CLKS)
                                               : ((WPUL_CLKS > WSET_CLKS) ? WPUL_CLKS : WSET_CLKS);
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CLKS - 1);
  localparam logic [CNT_W-1:0] WSET_LAST = CNT_W'(WSET_CLKS - 1);
  localparam logic [CNT_W-1:0] WPUL_LAST = CNT_W'(WPUL_CLKS - 1);

  ctl_state_t       st_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d, done_q;

  always_comb begin
    st_next = st_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    capture = 1'b0;
    done_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          cnt_d   = '0;
          st_next = req_write ? ST_WSET : ST_READ;
        end
      end
      ST_READ: begin
        if (cnt_q == RD_LAST) begin
          capture = 1'b1;
          done_d  = 1'b1;
          st_next = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WSET: begin
        if (cnt_q == WSET_LAST) begin
          cnt_d   = '0;
          st_next = ST_WPULS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WPULS: begin
        if (cnt_q == WPUL_LAST) begin
          done_d  = 1'b1;
          st_next = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_next = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_next;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/sram_ctl_pins.sv
`timescale 1ns/1ps
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_t        st_next,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_o
);
  logic ce_n_d, oe_n_d, we_n_d, dq_oe_d;
  logic addr_en, data_en;

  always_comb begin
    ce_n_d  = (st_next == ST_IDLE);
    oe_n_d  = (st_next != ST_READ);
    we_n_d  = (st_next != ST_WPULS);
    dq_oe_d = (st_next == ST_WPULS);
    addr_en = accept;
    data_en = accept & req_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= ce_n_d;
      oe_n  <= oe_n_d;
      we_n  <= we_n_d;
      dq_oe <= dq_oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (addr_en) begin
      addr <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_o <= '0;
    end else if (data_en) begin
      dq_o <= req_wdata;
    end
  end
endmodule

// File: rtl/sram_ctl_rdreg.sv
`timescale 1ns/1ps
module sram_ctl_rdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (capture) begin
      rdata <= dq_i;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int RD_CLKS   = 2,
  parameter int WSET_CLKS = 1,
  parameter int WPUL_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  ctl_state_t st_next;
  logic       accept, capture;

  sram_ctl_seq #(
    .RD_CLKS  (RD_CLKS),
    .WSET_CLKS(WSET_CLKS),
    .WPUL_CLKS(WPUL_CLKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_write(req_write),
    .st_next  (st_next),
    .accept   (accept),
    .capture  (capture),
    .done     (ready)
  );

  sram_ctl_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_next  (st_next),
    .accept   (accept),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .ce_n     (sram_ce_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n),
    .dq_oe    (sram_dq_oe),
    .addr     (sram_addr),
    .dq_o     (sram_dq_o)
  );

  sram_ctl_rdreg #(
    .DATA_W(DATA_W)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(capture),
    .dq_i   (sram_dq_i),
    .rdata  (rdata)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe
);
  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_ce_n && sram_we_n));

  a_r5_we_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n));

  a_r5_pulse_two: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |=> !sram_we_n);

  a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_dq_o));

  a_r6_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> ($rose(sram_ce_n) && !sram_dq_oe));

  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && !sram_we_n));

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .sram_ce_n (sram_ce_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .sram_addr (sram_addr),
  .sram_dq_o (sram_dq_o),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;
  logic        clk;
  logic        rst_n;
  logic        req;
  logic        req_write;
  logic [10:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ready;
  logic [7:0]  rdata;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [10:0] sram_addr;
  logic [7:0]  sram_dq_o;
  logic [7:0]  sram_dq_i;

  int n_chk;
  int n_fail;
  bit finished;

  sram_ctl u_sram_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ready     (ready),
    .rdata     (rdata),
    .sram_ce_n (sram_ce_n),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .sram_addr (sram_addr),
    .sram_dq_o (sram_dq_o),
    .sram_dq_oe(sram_dq_oe),
    .sram_dq_i (sram_dq_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural memory: 15 ns access delay, checks strobe width, setup, contention
  logic [7:0] mem [0:2047];
  logic [7:0] mem_word;
  logic [7:0] mem_out;
  logic       mem_drv;
  realtime    t_wfall, t_dchg;
  bit         wr_on;
  logic [10:0] wr_addr;

  assign mem_word = mem[sram_addr];
  assign #15 mem_out = mem_word;
  assign mem_drv = !sram_ce_n && !sram_oe_n && sram_we_n;
  assign sram_dq_i = mem_drv ? mem_out : (sram_dq_oe ? sram_dq_o : 8'h00);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge sram_we_n) begin
    if (!sram_ce_n) begin
      wr_on   = 1'b1;
      t_wfall = $realtime;
      wr_addr = sram_addr;
    end
  end

  always @(sram_dq_o or posedge sram_dq_oe) t_dchg = $realtime;

  always @(posedge sram_we_n) begin
    if (wr_on) begin
      wr_on = 1'b0;
      chk(($realtime - t_wfall) >= 12.0, "R5 write pulse >=12ns", int'($realtime - t_wfall), 12);
      chk(($realtime - t_dchg) >= 10.0, "R5 data setup >=10ns", int'($realtime - t_dchg), 10);
      mem[wr_addr] = sram_dq_o;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_drv && sram_dq_oe)
      chk(1'b0, "R9 bus contention", 1, 0);
  end

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'(((a * 29) + salt) ^ (a >> 3));
  endfunction

  // One transfer; inj raises a stray write request mid-transfer
  task automatic op(input bit w, input logic [10:0] a, input logic [7:0] d,
                    input bit inj, output logic [7:0] rd);
    int n;
    @(negedge clk);
    req = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    n = 0;
    while (n < 10) begin
      @(negedge clk);
      n++;
      if (n == 1) req = 1'b0;
      if (w) begin
        if (n == 1)
          chk(!sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R4 write setup strobes",
              {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b0110);
        if (n == 2 || n == 3) begin
          chk(!sram_we_n && sram_dq_oe && !sram_ce_n, "R5 write pulse strobes",
              {sram_ce_n, sram_we_n, sram_dq_oe}, 3'b001);
          chk(sram_dq_o == d, "R5 write data", sram_dq_o, d);
        end
      end else if (n == 1 || n == 2) begin
        chk(!sram_ce_n && !sram_oe_n && sram_we_n, "R2 read strobes",
            {sram_ce_n, sram_oe_n, sram_we_n}, 3'b001);
      end
      if (!sram_ce_n)
        chk(sram_addr == a, "R10 address held", sram_addr, a);
      if (inj && n == 2) begin
        req = 1'b1; req_write = 1'b1; req_addr = a ^ 11'h400; req_wdata = ~d;
      end
      if (inj && n == 3) req = 1'b0;
      if (ready) break;
    end
    rd = rdata;
    chk(n == (w ? 4 : 3), w ? "R6 write latency" : "R2 read latency", n, w ? 4 : 3);
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R6 strobes released",
        {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
    @(negedge clk);
    chk(!ready, "R7 ready single cycle", ready, 0);
    req = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    logic [7:0] held;
    n_chk = 0; n_fail = 0; finished = 0; wr_on = 0;
    t_wfall = 0.0; t_dchg = 0.0; wr_addr = '0;
    req = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !ready, "R1 in reset",
        {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, ready}, 5'b11100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !ready, "R1 after reset",
        {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, ready}, 5'b11100);

    // Sweep 1: write every address, then read every address back
    for (int a = 0; a < 2048; a++) op(1'b1, 11'(a), pat(a, 0), 1'b0, rd);
    for (int a = 0; a < 2048; a++) begin
      op(1'b0, 11'(a), 8'h00, 1'b0, rd);
      chk(rd == pat(a, 0), "R3 readback sweep 1", rd, pat(a, 0));
    end

    // R3: rdata held across writes
    op(1'b0, 11'd5, 8'h00, 1'b0, held);
    op(1'b1, 11'd6, 8'h3C, 1'b0, rd);
    chk(rdata == held, "R3 rdata held across write", rdata, held);
    op(1'b1, 11'd6, pat(6, 0), 1'b0, rd);
    chk(rdata == held, "R3 rdata held across second write", rdata, held);

    // R8: stray requests mid-transfer are dropped
    op(1'b1, 11'd20, 8'hE1, 1'b1, rd);
    op(1'b0, 11'd20 ^ 11'h400, 8'h00, 1'b0, rd);
    chk(rd == pat(20 ^ 1024, 0), "R8 stray write during write dropped", rd, pat(20 ^ 1024, 0));
    op(1'b0, 11'd33, 8'h00, 1'b1, rd);
    chk(rd == pat(33, 0), "R8 read unaffected by stray request", rd, pat(33, 0));
    op(1'b0, 11'd33 ^ 11'h400, 8'h00, 1'b0, rd);
    chk(rd == pat(33 ^ 1024, 0), "R8 stray write during read dropped", rd, pat(33 ^ 1024, 0));
    op(1'b0, 11'd20, 8'h00, 1'b0, rd);
    chk(rd == 8'hE1, "R3 written byte read back", rd, 8'hE1);

    // Sweep 2: descending, write then immediate read, new pattern
    for (int a = 2047; a >= 0; a--) begin
      op(1'b1, 11'(a), pat(a, 77), 1'b0, rd);
      op(1'b0, 11'(a), 8'h00, 1'b0, rd);
      chk(rd == pat(a, 77), "R3 readback sweep 2", rd, pat(a, 77));
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule